// File: doc/BRIEF.md
# Collapsing Out-of-Order Issue Queue

The block is a small scheduling buffer placed between an in-order decode stage and a group of execution units. Each cycle decode may offer a handful of micro-ops on parallel lanes, and lanes may be empty. Every micro-op carries its source tags, a pending flag per source, a destination tag and the index of the execution unit it needs. Valid lanes are written into the queue in lane order. They are packed directly above the youngest entry already held, so the storage never contains holes.

Each cycle the queue looks at its stored entries and sends, for every free execution unit, the oldest entry that has no pending source and targets that unit. A younger micro-op can therefore leave ahead of an older one that is still blocked. In the same cycle the issued entries are removed and the survivors slide down without changing their relative age order. Result-tag broadcast ports clear matching pending flags: one port carries ALU results and another carries returning load data. A flush empties the queue in one cycle.

Top module: `cq_issue_queue`

## Requirements
- R1: After reset the queue is empty, no issue output is valid and `dec_ready_o` is high.
- R2: When `dec_ready_o` is high, every lane with its `dec_valid_i` bit set is taken. Lane 0 is the oldest. The taken ops are placed above the surviving entries in lane order, and empty lanes use no slot.
- R3: `dec_ready_o` is low whenever fewer than DEC_W slots are free or `flush_i` is high. Ops offered while it is low are not stored and never issue.
- R4: An entry is eligible only if none of its sources is pending and the busy input of its target unit is low. An op can first issue in the cycle after it is written.
- R5: A valid broadcast on any wakeup port clears, in the same cycle, each pending source whose tag equals the broadcast tag. This covers stored entries and ops entering in that cycle. The entry becomes eligible in the following cycle.
- R6: Issue is not bound to program order. A ready younger op issues while an older op that needs the same unit is still pending.
- R7: Each unit issues at most one op per cycle. When several eligible entries target one unit, the oldest one issues. The issued op appears on that unit's `iss_uop_o` field with the same encoding as on input.
- R8: Issued entries leave in the cycle they issue. The remaining entries keep their age order and sit in the lowest slots.
- R9: `flush_i` empties the queue at the next edge. No op issues and no op is taken during the flush cycle.
- R10: With one ready op offered per cycle and all units free, each op issues exactly one cycle after it is taken, and `dec_ready_o` stays high.

Micro-op encoding (19 bits, MSB first): `src[1]`(5) `src[0]`(5) `pend[1:0]`(2) `dst`(5) `unit`(2). Lane or unit k occupies bits `[k*19 +: 19]`. Wakeup port w uses `wb_tag_i[w*5 +: 5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the queue |
| dec_valid_i | input | DEC_W | Lane valid bits from decode |
| dec_uop_i | input | DEC_W*19 | Lane micro-ops |
| dec_ready_o | output | 1 | Queue can take a full group of lanes |
| wb_valid_i | input | NUM_WB | Wakeup port valid bits |
| wb_tag_i | input | NUM_WB*5 | Wakeup port tags |
| unit_busy_i | input | NUM_UNITS | Execution unit busy bits |
| iss_valid_o | output | NUM_UNITS | Issue valid per unit |
| iss_uop_o | output | NUM_UNITS*19 | Issued micro-op per unit |

## Verification
The bench builds the queue with DEPTH=6, DEC_W=3, three units and two wakeup ports. Because the depth is not a power of two, the slot counter and slot index carry codes that never appear, and the full-group threshold is crossed at an occupancy of four. This lets a short run fill the queue, stall decode and then drain it. Three units with a two-entry tag broadcast bring within reach same-unit age contention, out-of-order issue past a pending op, and a wakeup that lands on an op in its entry cycle.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int TAG_W  = 5;
  localparam int NSRC   = 2;
  localparam int UNIT_W = 2;

  typedef struct packed {
    logic [NSRC-1:0][TAG_W-1:0] src;
    logic [NSRC-1:0]            pend;
    logic [TAG_W-1:0]           dst;
    logic [UNIT_W-1:0]          unit;
  } uop_t;

  localparam int UOP_W = $bits(uop_t);
endpackage

// File: rtl/cq_wakeup.sv
module cq_wakeup
  import cq_pkg::*;
#(
  parameter int N      = 8,
  parameter int NUM_WB = 2
) (
  input  uop_t                    uop_i [N],
  input  logic [NUM_WB-1:0]       wb_valid_i,
  input  logic [NUM_WB*TAG_W-1:0] wb_tag_i,
  output uop_t                    uop_o [N]
);
  always_comb begin
    for (int e = 0; e < N; e++) begin
      uop_o[e] = uop_i[e];
      for (int s = 0; s < NSRC; s++)
        for (int w = 0; w < NUM_WB; w++)
          if (wb_valid_i[w] && uop_i[e].src[s] == wb_tag_i[w*TAG_W +: TAG_W])
            uop_o[e].pend[s] = 1'b0;
    end
  end
endmodule

// File: rtl/cq_select.sv
module cq_select
  import cq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_UNITS = 3,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]              rdy_i,
  input  logic [DEPTH-1:0][UNIT_W-1:0]  unit_i,
  input  logic [NUM_UNITS-1:0]          busy_i,
  input  logic                          flush_i,
  output logic [NUM_UNITS-1:0]          iss_valid_o,
  output logic [NUM_UNITS*IDX_W-1:0]    iss_idx_o,
  output logic [DEPTH-1:0]              grant_o
);
  logic [NUM_UNITS-1:0][DEPTH-1:0] gmask;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [DEPTH-1:0] cand;
    logic [DEPTH-1:0] one;
    logic [IDX_W-1:0] idx;
    logic             hit;
    always_comb begin
      for (int e = 0; e < DEPTH; e++)
        cand[e] = rdy_i[e] && (unit_i[e] == UNIT_W'(u));
      idx = '0;
      // scan high to low so the lowest (oldest) index wins
      for (int e = DEPTH - 1; e >= 0; e--)
        if (cand[e]) idx = IDX_W'(e);
      hit = (|cand) && !busy_i[u] && !flush_i;
      one = '0;
      if (hit) one[idx] = 1'b1;
    end
    assign iss_valid_o[u]                = hit;
    assign iss_idx_o[u*IDX_W +: IDX_W]  = idx;
    assign gmask[u]                      = one;
  end

  always_comb begin
    grant_o = '0;
    for (int u = 0; u < NUM_UNITS; u++) grant_o |= gmask[u];
  end
endmodule

// File: rtl/cq_compact.sv
module cq_compact
  import cq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DEC_W  = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] keep_i,
  input  uop_t             ent_i [DEPTH],
  input  logic [DEC_W-1:0] in_valid_i,
  input  uop_t             in_uop_i [DEC_W],
  output logic [DEPTH-1:0] valid_o,
  output uop_t             uop_o [DEPTH]
);
  logic [CNT_W-1:0] pos;

  always_comb begin
    pos     = '0;
    valid_o = '0;
    for (int e = 0; e < DEPTH; e++) uop_o[e] = '0;
    for (int i = 0; i < DEPTH; i++)
      if (keep_i[i] && pos < CNT_W'(DEPTH)) begin
        uop_o[pos[IDX_W-1:0]]   = ent_i[i];
        valid_o[pos[IDX_W-1:0]] = 1'b1;
        pos = pos + 1'b1;
      end
    for (int l = 0; l < DEC_W; l++)
      if (in_valid_i[l] && pos < CNT_W'(DEPTH)) begin
        uop_o[pos[IDX_W-1:0]]   = in_uop_i[l];
        valid_o[pos[IDX_W-1:0]] = 1'b1;
        pos = pos + 1'b1;
      end
  end
endmodule

// File: rtl/cq_issue_queue.sv
module cq_issue_queue
  import cq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int DEC_W     = 3,
  parameter int NUM_UNITS = 3,
  parameter int NUM_WB    = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic [DEC_W-1:0]             dec_valid_i,
  input  logic [DEC_W*UOP_W-1:0]       dec_uop_i,
  output logic                         dec_ready_o,
  input  logic [NUM_WB-1:0]            wb_valid_i,
  input  logic [NUM_WB*TAG_W-1:0]      wb_tag_i,
  input  logic [NUM_UNITS-1:0]         unit_busy_i,
  output logic [NUM_UNITS-1:0]         iss_valid_o,
  output logic [NUM_UNITS*UOP_W-1:0]   iss_uop_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]              q_valid, nxt_valid, grant, rdy, keep;
  uop_t                          q_uop [DEPTH];
  uop_t                          q_woke [DEPTH];
  uop_t                          nxt_uop [DEPTH];
  uop_t                          in_raw [DEC_W];
  uop_t                          in_woke [DEC_W];
  uop_t                          iss_u [NUM_UNITS];
  logic [DEPTH-1:0][UNIT_W-1:0]  q_unit;
  logic [NUM_UNITS*IDX_W-1:0]    iss_idx;
  logic [DEC_W-1:0]              in_valid;
  logic [CNT_W-1:0]              occ, n_iss, n_acc;

  assign occ         = CNT_W'($countones(q_valid));
  assign dec_ready_o = !flush_i && (CNT_W'(DEPTH) - occ >= CNT_W'(DEC_W));
  assign in_valid    = dec_valid_i & {DEC_W{dec_ready_o}};
  assign keep        = q_valid & ~grant;
  assign n_iss       = CNT_W'($countones(iss_valid_o));
  assign n_acc       = CNT_W'($countones(in_valid));

  always_comb begin
    for (int l = 0; l < DEC_W; l++) in_raw[l] = dec_uop_i[l*UOP_W +: UOP_W];
    for (int e = 0; e < DEPTH; e++) begin
      rdy[e]    = q_valid[e] && (q_uop[e].pend == '0);
      q_unit[e] = q_uop[e].unit;
    end
    for (int u = 0; u < NUM_UNITS; u++) begin
      iss_u[u] = q_uop[iss_idx[u*IDX_W +: IDX_W]];
      iss_uop_o[u*UOP_W +: UOP_W] = iss_u[u];
    end
  end

  cq_wakeup #(.N(DEPTH), .NUM_WB(NUM_WB)) u_wake_q (
    .uop_i(q_uop), .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .uop_o(q_woke));

  cq_wakeup #(.N(DEC_W), .NUM_WB(NUM_WB)) u_wake_in (
    .uop_i(in_raw), .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .uop_o(in_woke));

  cq_select #(.DEPTH(DEPTH), .NUM_UNITS(NUM_UNITS)) u_sel (
    .rdy_i(rdy), .unit_i(q_unit), .busy_i(unit_busy_i), .flush_i(flush_i),
    .iss_valid_o(iss_valid_o), .iss_idx_o(iss_idx), .grant_o(grant));

  cq_compact #(.DEPTH(DEPTH), .DEC_W(DEC_W)) u_cmp (
    .keep_i(keep), .ent_i(q_woke), .in_valid_i(in_valid), .in_uop_i(in_woke),
    .valid_o(nxt_valid), .uop_o(nxt_uop));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_valid <= '0;
      for (int e = 0; e < DEPTH; e++) q_uop[e] <= '0;
    end else if (flush_i) begin
      q_valid <= '0;
    end else begin
      q_valid <= nxt_valid;
      q_uop   <= nxt_uop;
    end
  end

  // R9
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (q_valid == '0));

  // R8
  packed_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q_valid + DEPTH'(1)) & q_valid) == '0);

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (occ == $past(occ) - $past(n_iss) + $past(n_acc)));

  // R7
  one_entry_per_unit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant) == $countones(iss_valid_o));

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    // R4
    issue_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_valid_o[u] |-> (iss_u[u].pend == '0) && !unit_busy_i[u]
                          && (iss_u[u].unit == UNIT_W'(u)));
  end
endmodule

// File: tb/sim_cq_issue_queue.sv
module sim_cq_issue_queue;
  import cq_pkg::*;

  localparam int DEPTH = 6;
  localparam int DEC_W = 3;
  localparam int NU    = 3;
  localparam int NWB   = 2;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    flush = 1'b0;
  logic [DEC_W-1:0]        dv = '0;
  logic [DEC_W*UOP_W-1:0]  duop = '0;
  logic                    ready;
  logic [NWB-1:0]          wbv = '0;
  logic [NWB*TAG_W-1:0]    wbt = '0;
  logic [NU-1:0]           busy = '0;
  logic [NU-1:0]           iv;
  logic [NU*UOP_W-1:0]     iuop;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  uop_t mq[$];

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  cq_issue_queue #(.DEPTH(DEPTH), .DEC_W(DEC_W), .NUM_UNITS(NU), .NUM_WB(NWB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .dec_valid_i(dv), .dec_uop_i(duop), .dec_ready_o(ready),
    .wb_valid_i(wbv), .wb_tag_i(wbt), .unit_busy_i(busy),
    .iss_valid_o(iv), .iss_uop_o(iuop));

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic uop_t wake(input uop_t x);
    uop_t y = x;
    for (int s = 0; s < NSRC; s++)
      for (int w = 0; w < NWB; w++)
        if (wbv[w] && x.src[s] == wbt[w*TAG_W +: TAG_W]) y.pend[s] = 1'b0;
    return y;
  endfunction

  function automatic uop_t mk(input int unit, input int s0, input int s1,
                              input bit p0, input bit p1, input int dst);
    uop_t x;
    x.src[0] = TAG_W'(s0); x.src[1] = TAG_W'(s1);
    x.pend = {p1, p0};
    x.dst = TAG_W'(dst); x.unit = UNIT_W'(unit);
    return x;
  endfunction

  function automatic uop_t rnd(input int pend_pct);
    return mk($urandom_range(0, NU-1), $urandom_range(0, 31), $urandom_range(0, 31),
              $urandom_range(0, 99) < pend_pct, $urandom_range(0, 99) < pend_pct,
              $urandom_range(0, 31));
  endfunction

  // called after inputs are set at a falling edge; compares, then advances the model
  task automatic step(input string req);
    bit   exp_ready;
    bit   exp_iv [NU];
    int   exp_idx [NU];
    bit   gone [DEPTH];
    uop_t nq[$];
    #2;
    exp_ready = !flush && (DEPTH - mq.size() >= DEC_W);
    for (int i = 0; i < DEPTH; i++) gone[i] = 1'b0;
    for (int u = 0; u < NU; u++) begin
      exp_iv[u] = 1'b0; exp_idx[u] = 0;
      if (!flush && !busy[u])
        for (int i = 0; i < mq.size(); i++)
          if (!exp_iv[u] && int'(mq[i].unit) == u && mq[i].pend == '0) begin
            exp_iv[u] = 1'b1; exp_idx[u] = i; gone[i] = 1'b1;
          end
    end
    check(req, "ready", 64'(ready), 64'(exp_ready));
    for (int u = 0; u < NU; u++) begin
      check(req, "iss_valid", 64'(iv[u]), 64'(exp_iv[u]));
      if (exp_iv[u])
        check(req, "iss_uop", 64'(iuop[u*UOP_W +: UOP_W]), 64'(mq[exp_idx[u]]));
    end
    @(posedge clk);
    if (flush) mq.delete();
    else begin
      for (int i = 0; i < mq.size(); i++) if (!gone[i]) nq.push_back(wake(mq[i]));
      if (exp_ready)
        for (int l = 0; l < DEC_W; l++)
          if (dv[l]) nq.push_back(wake(uop_t'(duop[l*UOP_W +: UOP_W])));
      mq = nq;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 1'b0; dv = '0; wbv = '0; busy = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    idle(); step("R1");

    // R3: fill while all units busy; ready falls at occupancy 4, extra offers dropped
    busy = '1;
    for (int c = 0; c < 5; c++) begin
      dv = '1;
      for (int l = 0; l < DEC_W; l++) duop[l*UOP_W +: UOP_W] = rnd(0);
      step("R3");
    end
    // R7: release units, oldest per unit drains first
    idle();
    for (int c = 0; c < 8; c++) step("R7");

    // R2: bubble lanes packed away
    busy = '1;
    for (int c = 0; c < 3; c++) begin
      dv = (c == 0) ? 3'b101 : 3'b010;
      for (int l = 0; l < DEC_W; l++) duop[l*UOP_W +: UOP_W] = rnd(0);
      step("R2");
    end
    idle();
    for (int c = 0; c < 4; c++) step("R2");

    // R6: older pending op on unit 0, younger ready op on unit 0 passes it
    dv = 3'b011;
    duop[0 +: UOP_W]     = mk(0, 7, 3, 1'b1, 1'b0, 10);
    duop[UOP_W +: UOP_W] = mk(0, 4, 5, 1'b0, 1'b0, 11);
    step("R6");
    idle(); step("R6"); step("R6");
    // R5: broadcast on the load port wakes the stored op
    wbv = 2'b10; wbt = {5'd7, 5'd0}; step("R5");
    idle(); step("R5");

    // R5: wakeup in the same cycle the op enters
    dv = 3'b001; duop[0 +: UOP_W] = mk(1, 9, 9, 1'b1, 1'b1, 12);
    wbv = 2'b01; wbt = {5'd0, 5'd9};
    step("R5");
    idle(); step("R5"); step("R5");

    // R9: flush with queue holding blocked work
    busy = '1;
    for (int c = 0; c < 2; c++) begin
      dv = '1;
      for (int l = 0; l < DEC_W; l++) duop[l*UOP_W +: UOP_W] = rnd(0);
      step("R9");
    end
    idle(); flush = 1'b1; dv = '1; step("R9");
    idle(); step("R9"); step("R9");

    // R10: lock-step flow, one ready op per cycle
    for (int c = 0; c < 20; c++) begin
      dv = 3'b001 << (c % DEC_W);
      for (int l = 0; l < DEC_W; l++) duop[l*UOP_W +: UOP_W] = rnd(0);
      step("R10");
    end
    idle(); step("R10");

    // R4/R8: random traffic with pending sources, busy units, wakeups
    for (int c = 0; c < 3000; c++) begin
      flush = ($urandom_range(0, 199) == 0);
      dv    = DEC_W'($urandom_range(0, 7));
      for (int l = 0; l < DEC_W; l++) duop[l*UOP_W +: UOP_W] = rnd(35);
      wbv   = NWB'($urandom_range(0, 3));
      wbt   = (NWB*TAG_W)'($urandom);
      busy  = NU'($urandom_range(0, 7)) & NU'($urandom_range(0, 7));
      step((c % 2 == 0) ? "R4" : "R8");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule